// File: doc/BRIEF.md
# Allocation Parameter Memory Initializer

This block sits between a configuration register bank and the bandwidth scheduler of an optical access MAC. The register bank hands it records that have already been validated. One kind of record describes an allocation identifier. It carries an activate flag, maximum and minimum bandwidth values, a minimum service interval and a 16-bit flags word. The other kind of record describes an ONU, with its activate and FEC-enable bits. The block turns each allocation record into writes to two external memories: a 48-bit parameter memory and a 15-bit service-interval timer memory. It also keeps one bit per ONU in a 128-bit active vector and in a 128-bit FEC-enabled vector.

The scheduler has its own port on the timer memory, and that port has priority. While the scheduler address is nonzero, the block holds its timer write as pending. It performs the write in the first cycle in which that address is zero. Apart from this, the block counts clock cycles to produce a frame strobe, one cycle long, once per frame. It also keeps a 16-bit frame number that steps with each strobe. At a 77.76 MHz system clock, a frame length input of 9720 gives one strobe every 125 us.

Top module: `alloc_param_init`

## Requirements
- R1: `frameTick` is high for exactly one cycle out of every `frameLen` cycles, with `frameLen` of 2 or more. It is first high in the cycle after the `frameLen`-th rising clock edge that follows reset release.
- R2: `frameNum` resets to 0. It increases by one at the same edge that raises `frameTick`, and it does not change at any other edge.
- R3: An `allocValid` pulse with the activate bit set (bit 10 of `allocRec`) raises `paramEn` and `paramWe` for exactly one cycle, in the cycle after the pulse. In that cycle `paramAddr` equals `allocRec[9:0]` and `paramData` equals {maxTb, minTb, flagsWord}, with maxTb in bits 47:32.
- R4: An `allocValid` pulse with the activate bit clear produces no parameter-memory write. It does produce one timer-memory write to `allocRec[9:0]` with the data word 15'h0000.
- R5: The timer word written for an activated allocation has bits 14:13 equal to 2'b11, which marks the allocation active. Bits 12:0 hold `minSdi`, and the address is `allocRec[9:0]`.
- R6: `timerEn` and `timerWe` are never high while `schedAddr` is nonzero. A pending timer write is performed in the first cycle after the capturing edge in which `schedAddr` is zero.
- R7: Each allocation record produces exactly one timer write, which lasts one cycle. A record that arrives while an earlier timer write is still pending replaces it, so only the newer record is written.
- R8: An `onuValid` pulse uses `onuRec` as follows: bit 9 is FEC enable, bit 8 is activate, and bits 7:0 are the ONU ID. From the next cycle, `onuActive[id]` equals the activate bit and `onuFec[id]` equals the FEC bit. All other bits are unchanged.
- R9: An `onuValid` pulse whose ONU ID is 128 or above leaves both ONU vectors unchanged.
- R10: While `rstN` is low, both ONU vectors, `frameNum`, `frameTick`, `paramEn` and `timerEn` are zero, and no timer write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameLen | input | 14 | Frame length in clock cycles |
| allocValid | input | 1 | One-cycle pulse: allocation record is valid |
| allocRec | input | 11 | Bit 10 activate, bits 9:0 allocation ID |
| maxTb | input | 16 | Maximum bandwidth value |
| minTb | input | 16 | Minimum bandwidth value |
| minSdi | input | 13 | Minimum service interval (timer load value) |
| flagsWord | input | 16 | Reserved/flags word (container type, FEC, reporting mode) |
| onuValid | input | 1 | One-cycle pulse: ONU record is valid |
| onuRec | input | 10 | Bit 9 FEC enable, bit 8 activate, bits 7:0 ONU ID |
| schedAddr | input | 10 | Scheduler timer-memory address; nonzero means busy |
| paramEn | output | 1 | Parameter memory enable |
| paramWe | output | 1 | Parameter memory write enable |
| paramAddr | output | 10 | Parameter memory address |
| paramData | output | 48 | Parameter memory write data |
| timerEn | output | 1 | Timer memory enable |
| timerWe | output | 1 | Timer memory write enable |
| timerAddr | output | 10 | Timer memory address |
| timerData | output | 15 | Timer memory write data |
| onuActive | output | 128 | One bit per active ONU |
| onuFec | output | 128 | One bit per FEC-enabled ONU |
| frameNum | output | 16 | Frame counter |
| frameTick | output | 1 | One-cycle strobe at each frame start |

## Verification
The bench builds the block with its default parameters: 10-bit allocation IDs, 16-bit bandwidth fields, 13-bit intervals and 128 ONUs. At these sizes it can activate all 1024 allocation addresses and send ONU records for every ID from 0 to 255, so the ignored upper half of the ID range is covered too. Because the frame length is a port, the strobe is swept over every length from 2 to 12, with reset in between, and then checked at 9720. Scheduler busy windows of 0 to 3 cycles are cycled through the allocation sweep, and one case has a second record arriving while the first write is still deferred.

// File: rtl/alloc_param_pkg.sv
`timescale 1ns/1ps
package alloc_param_pkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic paramWrite;  // capture parameter word, pulse memory enable
    logic timerLoad;   // capture timer word into the pending slot
    logic timerFire;   // pending slot is written this cycle
    logic onuUpdate;   // apply ONU record to the vectors
    logic frameWrap;   // last cycle of the current frame
  } ctrlStrobes_t;

  localparam logic [1:0] TIMER_ACTIVE = 2'b11;
  localparam logic [1:0] TIMER_IDLE   = 2'b00;

endpackage

// File: rtl/alloc_param_ctrl.sv
`timescale 1ns/1ps
module alloc_param_ctrl
  import alloc_param_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int FLEN_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FLEN_W-1:0] frameLen,
  input  logic              allocValid,
  input  logic              allocAct,
  input  logic              onuValid,
  input  logic [ID_W-1:0]   schedAddr,
  output ctrlStrobes_t      strobes
);

  logic [FLEN_W-1:0] cycCnt;
  logic              lastCycle;
  logic              pending;
  logic              schedIdle;

  assign lastCycle = ({1'b0, cycCnt} + (FLEN_W+1)'(1)) >= {1'b0, frameLen};
  assign schedIdle = (schedAddr == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCnt <= '0;
    end else if (lastCycle) begin
      cycCnt <= '0;
    end else begin
      cycCnt <= cycCnt + FLEN_W'(1);
    end
  end

  // Deferred timer write: a new record always (re)arms the slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (allocValid) begin
      pending <= 1'b1;
    end else if (schedIdle) begin
      pending <= 1'b0;
    end
  end

  always_comb begin
    strobes.paramWrite = allocValid & allocAct;
    strobes.timerLoad  = allocValid;
    strobes.timerFire  = pending & schedIdle;
    strobes.onuUpdate  = onuValid;
    strobes.frameWrap  = lastCycle;
  end

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(frameLen) && frameLen >= FLEN_W'(2)) |-> (cycCnt < frameLen));

  assert_pending_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !schedIdle) |=> pending);

endmodule

// File: rtl/alloc_param_dp.sv
`timescale 1ns/1ps
module alloc_param_dp
  import alloc_param_pkg::*;
#(
  parameter int ID_W    = 10,
  parameter int TB_W    = 16,
  parameter int SDI_W   = 13,
  parameter int FLAGS_W = 16,
  parameter int ONU_CNT = 128,
  parameter int ONU_ID_W = 8,
  parameter int FNUM_W  = 16,
  localparam int PARAM_W = 2*TB_W + FLAGS_W,
  localparam int TIMER_W = 2 + SDI_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic                allocAct,
  input  logic [ID_W-1:0]     allocId,
  input  logic [TB_W-1:0]     maxTb,
  input  logic [TB_W-1:0]     minTb,
  input  logic [SDI_W-1:0]    minSdi,
  input  logic [FLAGS_W-1:0]  flagsWord,
  input  logic [ONU_ID_W+1:0] onuRec,
  output logic                paramEn,
  output logic [ID_W-1:0]     paramAddr,
  output logic [PARAM_W-1:0]  paramData,
  output logic                timerEn,
  output logic [ID_W-1:0]     timerAddr,
  output logic [TIMER_W-1:0]  timerData,
  output logic [ONU_CNT-1:0]  onuActive,
  output logic [ONU_CNT-1:0]  onuFec,
  output logic [FNUM_W-1:0]   frameNum,
  output logic                frameTick
);

  localparam int ONU_IDX_W = $clog2(ONU_CNT);
  localparam logic [ONU_ID_W:0] ONU_LIMIT = ONU_CNT[ONU_ID_W:0];

  logic [ONU_ID_W-1:0]  onuId;
  logic [ONU_IDX_W-1:0] onuIdx;
  logic                 onuInRange;
  logic                 onuAct;
  logic                 onuFecBit;

  assign onuId      = onuRec[ONU_ID_W-1:0];
  assign onuIdx     = onuId[ONU_IDX_W-1:0];
  assign onuAct     = onuRec[ONU_ID_W];
  assign onuFecBit  = onuRec[ONU_ID_W+1];
  assign onuInRange = ({1'b0, onuId} < ONU_LIMIT);

  // Parameter memory port: registered, one-cycle write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      paramEn   <= 1'b0;
      paramAddr <= '0;
      paramData <= '0;
    end else begin
      paramEn <= strobes.paramWrite;
      if (strobes.paramWrite) begin
        paramAddr <= allocId;
        paramData <= {maxTb, minTb, flagsWord};
      end
    end
  end

  // Pending timer word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerAddr <= '0;
      timerData <= '0;
    end else if (strobes.timerLoad) begin
      timerAddr <= allocId;
      timerData <= allocAct ? {TIMER_ACTIVE, minSdi} : {TIMER_IDLE, {SDI_W{1'b0}}};
    end
  end

  assign timerEn = strobes.timerFire;

  // ONU vectors: one flop pair per ONU
  for (genvar g = 0; g < ONU_CNT; g++) begin : g_onu
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        onuActive[g] <= 1'b0;
        onuFec[g]    <= 1'b0;
      end else if (strobes.onuUpdate && onuInRange && onuIdx == ONU_IDX_W'(g)) begin
        onuActive[g] <= onuAct;
        onuFec[g]    <= onuFecBit;
      end
    end
  end

  // Frame strobe and number
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameTick <= 1'b0;
      frameNum  <= '0;
    end else begin
      frameTick <= strobes.frameWrap;
      if (strobes.frameWrap) begin
        frameNum <= frameNum + FNUM_W'(1);
      end
    end
  end

  assert_fnum_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(frameNum) |-> (frameTick && frameNum == $past(frameNum) + FNUM_W'(1)));

  assert_onu_ignore_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.onuUpdate && !onuInRange) |=> ($stable(onuActive) && $stable(onuFec)));

endmodule

// File: rtl/alloc_param_init.sv
`timescale 1ns/1ps
module alloc_param_init
  import alloc_param_pkg::*;
#(
  parameter int ID_W     = 10,
  parameter int TB_W     = 16,
  parameter int SDI_W    = 13,
  parameter int FLAGS_W  = 16,
  parameter int ONU_CNT  = 128,
  parameter int ONU_ID_W = 8,
  parameter int FNUM_W   = 16,
  parameter int FLEN_W   = 14,
  localparam int PARAM_W = 2*TB_W + FLAGS_W,
  localparam int TIMER_W = 2 + SDI_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [FLEN_W-1:0]   frameLen,
  input  logic                allocValid,
  input  logic [ID_W:0]       allocRec,
  input  logic [TB_W-1:0]     maxTb,
  input  logic [TB_W-1:0]     minTb,
  input  logic [SDI_W-1:0]    minSdi,
  input  logic [FLAGS_W-1:0]  flagsWord,
  input  logic                onuValid,
  input  logic [ONU_ID_W+1:0] onuRec,
  input  logic [ID_W-1:0]     schedAddr,
  output logic                paramEn,
  output logic                paramWe,
  output logic [ID_W-1:0]     paramAddr,
  output logic [PARAM_W-1:0]  paramData,
  output logic                timerEn,
  output logic                timerWe,
  output logic [ID_W-1:0]     timerAddr,
  output logic [TIMER_W-1:0]  timerData,
  output logic [ONU_CNT-1:0]  onuActive,
  output logic [ONU_CNT-1:0]  onuFec,
  output logic [FNUM_W-1:0]   frameNum,
  output logic                frameTick
);

  ctrlStrobes_t strobes;
  logic         allocAct;

  assign allocAct = allocRec[ID_W];

  alloc_param_ctrl #(.ID_W(ID_W), .FLEN_W(FLEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameLen(frameLen),
    .allocValid(allocValid), .allocAct(allocAct),
    .onuValid(onuValid), .schedAddr(schedAddr), .strobes(strobes)
  );

  alloc_param_dp #(
    .ID_W(ID_W), .TB_W(TB_W), .SDI_W(SDI_W), .FLAGS_W(FLAGS_W),
    .ONU_CNT(ONU_CNT), .ONU_ID_W(ONU_ID_W), .FNUM_W(FNUM_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .allocAct(allocAct), .allocId(allocRec[ID_W-1:0]),
    .maxTb(maxTb), .minTb(minTb), .minSdi(minSdi), .flagsWord(flagsWord),
    .onuRec(onuRec),
    .paramEn(paramEn), .paramAddr(paramAddr), .paramData(paramData),
    .timerEn(timerEn), .timerAddr(timerAddr), .timerData(timerData),
    .onuActive(onuActive), .onuFec(onuFec),
    .frameNum(frameNum), .frameTick(frameTick)
  );

  assign paramWe = paramEn;
  assign timerWe = timerEn;

  assert_param_src_R3: assert property (@(posedge clk) disable iff (!rstN)
    paramEn |-> ($past(allocValid) && $past(allocRec[ID_W])));

  assert_defer_R6: assert property (@(posedge clk) disable iff (!rstN)
    (schedAddr != '0) |-> !timerEn);

  assert_single_fire_R7: assert property (@(posedge clk) disable iff (!rstN)
    (timerEn && !allocValid) |=> !timerEn);

  assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    (frameTick && frameLen >= FLEN_W'(2)) |=> !frameTick);

endmodule

// File: tb/alloc_param_init_bench.sv
`timescale 1ns/1ps
module alloc_param_init_bench;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [13:0]  frameLen = 14'd9720;
  logic         allocValid = 1'b0;
  logic [10:0]  allocRec = '0;
  logic [15:0]  maxTb = '0, minTb = '0, flagsWord = '0;
  logic [12:0]  minSdi = '0;
  logic         onuValid = 1'b0;
  logic [9:0]   onuRec = '0;
  logic [9:0]   schedAddr = '0;
  logic         paramEn, paramWe, timerEn, timerWe, frameTick;
  logic [9:0]   paramAddr, timerAddr;
  logic [47:0]  paramData;
  logic [14:0]  timerData;
  logic [127:0] onuActive, onuFec;
  logic [15:0]  frameNum;

  int  nCmp = 0;
  int  nBad = 0;
  bit  done = 0;
  logic [127:0] expAct = '0, expFec = '0;

  always #2.5 clk = ~clk;

  alloc_param_init u_alloc_param_init (
    .clk(clk), .rstN(rstN), .frameLen(frameLen), .allocValid(allocValid),
    .allocRec(allocRec), .maxTb(maxTb), .minTb(minTb), .minSdi(minSdi),
    .flagsWord(flagsWord), .onuValid(onuValid), .onuRec(onuRec),
    .schedAddr(schedAddr), .paramEn(paramEn), .paramWe(paramWe),
    .paramAddr(paramAddr), .paramData(paramData), .timerEn(timerEn),
    .timerWe(timerWe), .timerAddr(timerAddr), .timerData(timerData),
    .onuActive(onuActive), .onuFec(onuFec), .frameNum(frameNum),
    .frameTick(frameTick)
  );

  task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nCmp++;
    if (ok !== 1'b1) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkReset();
    chk(paramEn === 1'b0 && timerEn === 1'b0 && frameTick === 1'b0, "R10 enables/tick", {paramEn, timerEn, frameTick}, 3'b0);
    chk(frameNum === 16'd0, "R10 frameNum", frameNum, 0);
    chk(onuActive === '0 && onuFec === '0, "R10 ONU vectors", onuActive | onuFec, 0);
  endtask

  task automatic frameSweep(input int len, input int cycles);
    @(posedge clk); #1; rstN = 1'b0; frameLen = 14'(len);
    @(negedge clk); checkReset();
    @(posedge clk); #1; rstN = 1'b1;
    for (int k = 1; k <= cycles; k++) begin
      @(posedge clk); @(negedge clk);
      chk(frameTick === (k % len == 0), "R1 frame tick", frameTick, (k % len == 0));
      chk(frameNum === 16'(k / len), "R2 frame number", frameNum, 16'(k / len));
      chk(timerEn === 1'b0 && paramEn === 1'b0, "R6 idle memories", {timerEn, paramEn}, 0);
    end
  endtask

  task automatic allocOp(input logic act, input logic [9:0] id, input logic [15:0] mx,
                         input logic [15:0] mn, input logic [15:0] fl, input logic [12:0] sdi,
                         input int busy);
    logic [14:0] expT;
    expT = act ? {2'b11, sdi} : 15'h0000;
    @(posedge clk); #1;
    allocValid = 1'b1; allocRec = {act, id}; maxTb = mx; minTb = mn; flagsWord = fl; minSdi = sdi;
    schedAddr = (busy > 0) ? (10'(id) | 10'h200) : 10'h000;
    @(posedge clk); #1; allocValid = 1'b0;
    @(negedge clk);
    chk(paramEn === act && paramWe === act, act ? "R3 param write" : "R4 no param write", paramEn, act);
    if (act) begin
      chk(paramAddr === id, "R3 param addr", paramAddr, id);
      chk(paramData === {mx, mn, fl}, "R3 param data", paramData, {mx, mn, fl});
    end
    for (int j = 1; j <= busy; j++) begin
      chk(timerEn === 1'b0 && timerWe === 1'b0, "R6 write held while busy", timerEn, 0);
      @(posedge clk); #1;
      if (j == busy) schedAddr = 10'h000;
      @(negedge clk);
      chk(paramEn === 1'b0, "R3 single param pulse", paramEn, 0);
    end
    chk(timerEn === 1'b1 && timerWe === 1'b1, "R6 deferred write performed", timerEn, 1);
    chk(timerAddr === id, "R5 timer addr", timerAddr, id);
    chk(timerData === expT, act ? "R5 timer word" : "R4 inactive timer word", timerData, expT);
    @(posedge clk); @(negedge clk);
    chk(timerEn === 1'b0 && paramEn === 1'b0, "R7 single timer write", {timerEn, paramEn}, 0);
  endtask

  task automatic onuOp(input logic fec, input logic act, input logic [7:0] id);
    @(posedge clk); #1; onuValid = 1'b1; onuRec = {fec, act, id};
    if (id < 8'd128) begin
      expAct[id[6:0]] = act;
      expFec[id[6:0]] = fec;
    end
    @(posedge clk); #1; onuValid = 1'b0;
    @(negedge clk);
    chk(onuActive === expAct, (id < 8'd128) ? "R8 active vector" : "R9 ignored id active", onuActive, expAct);
    chk(onuFec === expFec, (id < 8'd128) ? "R8 FEC vector" : "R9 ignored id FEC", onuFec, expFec);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    // R1/R2/R10: frame lengths 2..12, then the nominal length
    for (int len = 2; len <= 12; len++) frameSweep(len, 4 * len);
    frameSweep(9720, 2 * 9720 + 3);

    // R3/R5/R6: activate every address, busy windows 0..3
    for (int id = 0; id < 1024; id++) begin
      allocOp(1'b1, 10'(id), 16'(id * 97 + 5), 16'(id * 31) ^ 16'hA5A5,
              16'(id * 13), 13'(id * 7 + 1), id % 4);
    end
    // R4: deactivate a spread of addresses
    for (int id = 0; id < 1024; id += 37) begin
      allocOp(1'b0, 10'(id), 16'hFFFF, 16'h1234, 16'hBEEF, 13'h1ABC, id % 3);
    end

    // R7: second record replaces a pending one
    @(posedge clk); #1; allocValid = 1'b1; allocRec = {1'b1, 10'h055}; minSdi = 13'h0AAA; schedAddr = 10'h005;
    @(posedge clk); #1; allocValid = 1'b0;
    @(negedge clk); chk(timerEn === 1'b0, "R6 busy first record", timerEn, 0);
    @(posedge clk); #1; allocValid = 1'b1; allocRec = {1'b1, 10'h2C3}; minSdi = 13'h1555;
    maxTb = 16'h0102; minTb = 16'h0304; flagsWord = 16'h0506;
    @(posedge clk); #1; allocValid = 1'b0;
    @(negedge clk);
    chk(timerEn === 1'b0, "R6 busy second record", timerEn, 0);
    chk(paramEn === 1'b1 && paramAddr === 10'h2C3, "R3 second param write", paramAddr, 10'h2C3);
    @(posedge clk); #1; schedAddr = 10'h000;
    @(negedge clk);
    chk(timerEn === 1'b1 && timerAddr === 10'h2C3, "R7 newer record written", timerAddr, 10'h2C3);
    chk(timerData === {2'b11, 13'h1555}, "R7 newer timer word", timerData, {2'b11, 13'h1555});
    @(posedge clk); @(negedge clk);
    chk(timerEn === 1'b0, "R7 older record dropped", timerEn, 0);

    // R8/R9: two passes over all 256 IDs
    for (int id = 0; id < 256; id++) onuOp(id % 3 == 0, 1'b1, 8'(id));
    for (int id = 0; id < 256; id++) onuOp(id % 5 == 0, id % 2 == 1, 8'(id));

    // R10: reset clears the vectors
    @(posedge clk); #1; rstN = 1'b0;
    @(negedge clk); checkReset();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule